// File: doc/BRIEF.md
# Two-Phase Oblivious Route Computation for a Two-Dimensional Flattened Butterfly

This unit computes the route of a head flit in one router of a two-dimensional flattened butterfly with K routers per dimension and C terminal nodes per router. It uses oblivious two-phase load balancing. A flit that enters from a terminal port is given a pseudo-random intermediate node. It first travels minimally to that node's router and then minimally to its real destination. The intermediate and the phase travel with the flit, so downstream routers continue the same route.

For each request the unit returns three things:
- the output port, correcting the X coordinate before the Y coordinate;
- a window of virtual channels inside the flit's traffic class;
- the updated intermediate and phase to write back into the flit.

The VC window depends on the phase. The two phases use disjoint halves of the class range until the flit reaches its destination router, and this removes cyclic channel dependencies between the phases. The result is registered and appears one cycle after the request.

Top module: `valiant_rc`

## Requirements
- R1: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. It is low during reset and on every other cycle.
- R2: When the input channel is a terminal port (`in_chan` < C), `intm_out` is a fresh draw in 0..K*K*C-1. For any other input channel, `intm_out` equals `intm_in`.
- R3: The starting phase is 0 for a terminal input and `phase_in` otherwise. `phase_out` is 1 if that starting phase is 1, or if the current router hosts the intermediate or the destination (node / C equals `router_id`). Otherwise it is 0.
- R4: While `phase_out` is 0, `out_port` is the minimal step toward the intermediate's router, and it is never a terminal port.
- R5: While `phase_out` is 1, the route targets `dest`. At the destination router, `out_port` is `dest` mod C.
- R6: Router r has X coordinate r mod K and Y coordinate r / K. Ports 0..C-1 are terminal ports. When the target router differs from the current one:
  - If the X coordinates differ, the port is C + tx, or C + tx - 1 when tx > cx.
  - Otherwise the port is C + K - 1 + ty, or C + K - 1 + ty - 1 when ty > cy.
- R7: Traffic class t (0 read request, 1 write request, 2 read reply, 3 write reply) owns VCs t*V..t*V+V-1. Away from the destination router:
  - Phase 0 gets `vc_lo` = t*V and `vc_hi` = t*V + V/2 - 1.
  - Phase 1 gets `vc_lo` = t*V + V/2 and `vc_hi` = t*V + V - 1.
- R8: When the current router is the destination router, the window is the whole class range t*V..t*V+V-1.
- R9: A flit arriving on a network port with phase 1 keeps phase 1 and targets its destination, even if it stands at its intermediate's router.
- R10: Each terminal-port request advances the pseudo-random source, so successive draws vary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| req_valid | input | 1 | A head flit presents a route request |
| router_id | input | RID_W | Identifier of this router |
| in_chan | input | PORT_W | Input channel of the flit; below C means a terminal port |
| dest | input | NODE_W | Destination node |
| intm_in | input | NODE_W | Intermediate node carried by the flit |
| phase_in | input | 1 | Phase carried by the flit |
| tclass | input | 2 | Traffic class |
| vc_in | input | VC_W | Current VC; lies in the class range for network inputs |
| rsp_valid | output | 1 | Registered result valid |
| out_port | output | PORT_W | Selected output port |
| vc_lo | output | VC_W | Lowest allowed VC |
| vc_hi | output | VC_W | Highest allowed VC |
| intm_out | output | NODE_W | Intermediate node to store in the flit |
| phase_out | output | 1 | Phase to store in the flit |

## Verification
The bench builds the unit with K=3, C=2 and four VCs per class. This gives 18 nodes, a count that is not a power of two, so the modulo reduction of the draw is exercised. With three routers per row, both port-numbering branches of R6 are reached: a target coordinate below the current one and a target coordinate above it. It also gives two-VC halves, so a window edge that is off by one shows up in `vc_lo` or `vc_hi`. The stimulus combines directed flits with randomly chosen routers, inputs, phases and classes. These cover phase changes at the intermediate router, arrival at the destination while still in phase 0, sticky phase 1, and terminal requests whose destination is local.

// File: rtl/route_pkg.sv
package route_pkg;

  typedef enum logic [1:0] {
    TC_RD_REQ = 2'd0,
    TC_WR_REQ = 2'd1,
    TC_RD_RSP = 2'd2,
    TC_WR_RSP = 2'd3
  } tclass_e;

  typedef enum logic {
    PH_TO_MID = 1'b0,
    PH_TO_DST = 1'b1
  } phase_e;

  localparam int          LFSR_W    = 16;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/rc_lfsr_draw.sv
module rc_lfsr_draw
  import route_pkg::*;
#(
  parameter int          NODES  = 32,
  parameter int          NODE_W = 5,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [NODE_W-1:0] draw
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (adv) begin
      lfsr_d = lfsr_q >> 1;
      if (lfsr_q[0]) lfsr_d = lfsr_d ^ LFSR_TAPS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign draw = NODE_W'(int'(lfsr_q) % NODES);

  p_lfsr_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  p_lfsr_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> lfsr_q != $past(lfsr_q));

endmodule

// File: rtl/rc_dor_port.sv
module rc_dor_port #(
  parameter int K      = 4,
  parameter int C      = 2,
  parameter int RID_W  = 4,
  parameter int NODE_W = 5,
  parameter int PORT_W = 3
) (
  input  logic [RID_W-1:0]  cur_rid,
  input  logic [NODE_W-1:0] tgt_node,
  output logic [PORT_W-1:0] port
);

  localparam int X_BASE = C;
  localparam int Y_BASE = C + K - 1;

  int tgt_r, cx, cy, tx, ty, sel;

  always_comb begin
    tgt_r = int'(tgt_node) / C;
    cx    = int'(cur_rid) % K;
    cy    = int'(cur_rid) / K;
    tx    = tgt_r % K;
    ty    = tgt_r / K;
    if (tgt_r == int'(cur_rid)) begin
      sel = int'(tgt_node) % C;
    end else if (tx != cx) begin
      sel = X_BASE + ((tx < cx) ? tx : tx - 1);
    end else begin
      sel = Y_BASE + ((ty < cy) ? ty : ty - 1);
    end
    port = PORT_W'(sel);
  end

endmodule

// File: rtl/rc_vc_window.sv
module rc_vc_window #(
  parameter int VPC  = 2,
  parameter int VC_W = 3
) (
  input  logic [1:0]      tclass,
  input  logic            to_dst,
  input  logic            full,
  output logic [VC_W-1:0] lo,
  output logic [VC_W-1:0] hi
);

  localparam int HALF = VPC / 2;

  int base;

  always_comb begin
    base = int'(tclass) * VPC;
    if (full) begin
      lo = VC_W'(base);
      hi = VC_W'(base + VPC - 1);
    end else if (to_dst) begin
      lo = VC_W'(base + HALF);
      hi = VC_W'(base + VPC - 1);
    end else begin
      lo = VC_W'(base);
      hi = VC_W'(base + HALF - 1);
    end
  end

endmodule

// File: rtl/valiant_rc.sv
module valiant_rc
  import route_pkg::*;
#(
  parameter int          K    = 4,
  parameter int          C    = 2,
  parameter int          VPC  = 2,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int ROUTERS = K * K,
  localparam int NODES   = ROUTERS * C,
  localparam int PORTS   = C + 2 * (K - 1),
  localparam int NUM_VC  = 4 * VPC,
  localparam int RID_W   = (ROUTERS > 1) ? $clog2(ROUTERS) : 1,
  localparam int NODE_W  = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int PORT_W  = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int VC_W    = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [RID_W-1:0]  router_id,
  input  logic [PORT_W-1:0] in_chan,
  input  logic [NODE_W-1:0] dest,
  input  logic [NODE_W-1:0] intm_in,
  input  logic              phase_in,
  input  logic [1:0]        tclass,
  input  logic [VC_W-1:0]   vc_in,
  output logic              rsp_valid,
  output logic [PORT_W-1:0] out_port,
  output logic [VC_W-1:0]   vc_lo,
  output logic [VC_W-1:0]   vc_hi,
  output logic [NODE_W-1:0] intm_out,
  output logic              phase_out
);

  localparam int HALF = VPC / 2;

  if (VPC < 2) begin : g_bad_vpc
    $error("each traffic class needs at least two VCs");
  end

  // ---------------------------------------------------------------- next state
  logic              from_client;
  logic [NODE_W-1:0] draw;
  logic [NODE_W-1:0] intm_eff;
  phase_e            ph_base, ph_d;
  logic              at_intm, at_dest;
  logic [NODE_W-1:0] tgt_node;
  logic [PORT_W-1:0] port_d;
  logic [VC_W-1:0]   lo_d, hi_d;

  assign from_client = int'(in_chan) < C;

  rc_lfsr_draw #(
    .NODES (NODES),
    .NODE_W(NODE_W),
    .SEED  (SEED)
  ) i_draw (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (req_valid && from_client),
    .draw (draw)
  );

  always_comb begin
    intm_eff = from_client ? draw : intm_in;
    ph_base  = from_client ? PH_TO_MID : phase_e'(phase_in);
    at_intm  = (int'(intm_eff) / C) == int'(router_id);
    at_dest  = (int'(dest) / C) == int'(router_id);
    ph_d     = (ph_base == PH_TO_DST || at_intm || at_dest) ? PH_TO_DST : PH_TO_MID;
    tgt_node = (ph_d == PH_TO_DST) ? dest : intm_eff;
  end

  rc_dor_port #(
    .K     (K),
    .C     (C),
    .RID_W (RID_W),
    .NODE_W(NODE_W),
    .PORT_W(PORT_W)
  ) i_dor (
    .cur_rid (router_id),
    .tgt_node(tgt_node),
    .port    (port_d)
  );

  rc_vc_window #(
    .VPC (VPC),
    .VC_W(VC_W)
  ) i_vcw (
    .tclass(tclass),
    .to_dst(ph_d == PH_TO_DST),
    .full  (at_dest),
    .lo    (lo_d),
    .hi    (hi_d)
  );

  // ---------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_port  <= '0;
      vc_lo     <= '0;
      vc_hi     <= '0;
      intm_out  <= '0;
      phase_out <= 1'b0;
    end else if (req_valid) begin
      out_port  <= port_d;
      vc_lo     <= lo_d;
      vc_hi     <= hi_d;
      intm_out  <= intm_eff;
      phase_out <= ph_d;
    end
  end

  // ---------------------------------------------------------------- checks
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_intm_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> int'(intm_out) < NODES);

  p_intm_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !from_client) |=> intm_out == $past(intm_in));

  p_mid_not_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !phase_out) |-> int'(out_port) >= C);

  p_port_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> int'(out_port) < PORTS);

  p_vc_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !from_client) |-> int'(vc_in) / VPC == int'(tclass));

  p_split_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && int'(out_port) >= C && !phase_out)
      |-> int'(vc_hi) - int'(vc_lo) + 1 == HALF);

  p_split_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && int'(out_port) >= C && phase_out)
      |-> int'(vc_hi) - int'(vc_lo) + 1 == VPC - HALF);

  p_full_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && int'(out_port) < C) |-> int'(vc_hi) - int'(vc_lo) + 1 == VPC);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !from_client && phase_in) |=> phase_out);

endmodule

// File: tb/test_valiant_rc.sv
module test_valiant_rc;

  localparam int TK      = 3;
  localparam int TC      = 2;
  localparam int TV      = 4;
  localparam int ROUTERS = TK * TK;
  localparam int NODES   = ROUTERS * TC;
  localparam int PORTS   = TC + 2 * (TK - 1);
  localparam int RID_W   = $clog2(ROUTERS);
  localparam int NODE_W  = $clog2(NODES);
  localparam int PORT_W  = $clog2(PORTS);
  localparam int VC_W    = $clog2(4 * TV);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [RID_W-1:0]  router_id;
  logic [PORT_W-1:0] in_chan;
  logic [NODE_W-1:0] dest;
  logic [NODE_W-1:0] intm_in;
  logic              phase_in;
  logic [1:0]        tclass;
  logic [VC_W-1:0]   vc_in;
  logic              rsp_valid;
  logic [PORT_W-1:0] out_port;
  logic [VC_W-1:0]   vc_lo;
  logic [VC_W-1:0]   vc_hi;
  logic [NODE_W-1:0] intm_out;
  logic              phase_out;

  always #5 clk = ~clk;

  valiant_rc #(.K(TK), .C(TC), .VPC(TV)) i_valiant_rc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .router_id(router_id),
    .in_chan(in_chan), .dest(dest), .intm_in(intm_in), .phase_in(phase_in),
    .tclass(tclass), .vc_in(vc_in), .rsp_valid(rsp_valid), .out_port(out_port),
    .vc_lo(vc_lo), .vc_hi(vc_hi), .intm_out(intm_out), .phase_out(phase_out)
  );

  typedef struct {
    int rid; int chan; int dst; int mid; int ph; int cls;
  } req_t;

  req_t q[$];
  int   draws[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;
  logic req_seen;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Reference route from the requirements, written in router coordinates.
  task automatic expect_route(input req_t r, input int mid,
                              output int port, output int lo, output int hi,
                              output int ph);
    int here_x, here_y, goal, goal_r, gx, gy, base;
    bit client;
    client = r.chan < TC;
    ph     = client ? 0 : r.ph;
    if (mid / TC == r.rid || r.dst / TC == r.rid) ph = 1;          // R3
    goal   = ph ? r.dst : mid;                                      // R4 R5
    goal_r = goal / TC;
    here_x = r.rid % TK;  here_y = r.rid / TK;
    gx     = goal_r % TK; gy     = goal_r / TK;
    if (goal_r == r.rid)  port = goal % TC;                         // R5
    else if (gx != here_x) port = TC + gx - ((gx > here_x) ? 1 : 0);  // R6
    else                   port = TC + TK - 1 + gy - ((gy > here_y) ? 1 : 0);
    base = r.cls * TV;
    if (r.dst / TC == r.rid) begin lo = base; hi = base + TV - 1; end   // R8
    else if (ph == 1) begin lo = base + TV / 2; hi = base + TV - 1; end // R7
    else begin lo = base; hi = base + TV / 2 - 1; end
  endtask

  task automatic drive(input int rid, input int chan, input int dst,
                       input int mid, input int ph, input int cls);
    req_t r;
    @(negedge clk);
    r = '{rid: rid, chan: chan, dst: dst, mid: mid, ph: ph, cls: cls};
    req_valid <= 1'b1;
    router_id <= RID_W'(rid);
    in_chan   <= PORT_W'(chan);
    dest      <= NODE_W'(dst);
    intm_in   <= NODE_W'(mid);
    phase_in  <= ph[0];
    tclass    <= cls[1:0];
    vc_in     <= VC_W'(cls * TV + (ph ? TV - 1 : 0));
    q.push_back(r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid <= 1'b0;
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) req_seen <= 1'b0;
    else        req_seen <= req_valid;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R1 rsp_valid timing", int'(rsp_valid), int'(req_seen));
      if (rsp_valid) begin
        if (q.size() == 0) begin
          chk("R1 response without request", 1, 0);
        end else begin
          req_t r;
          int mid, port, lo, hi, ph;
          r = q.pop_front();
          if (r.chan < TC) begin
            chk("R2 draw in range", int'(int'(intm_out) < NODES), 1);
            mid = int'(intm_out);
            draws.push_back(mid);
          end else begin
            chk("R2 intermediate kept", int'(intm_out), r.mid);
            mid = r.mid;
          end
          expect_route(r, mid, port, lo, hi, ph);
          chk("R3 phase", int'(phase_out), ph);
          chk("R4/R5/R6 port", int'(out_port), port);
          chk("R7/R8 vc_lo", int'(vc_lo), lo);
          chk("R7/R8 vc_hi", int'(vc_hi), hi);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; router_id = '0; in_chan = '0; dest = '0;
    intm_in = '0; phase_in = 1'b0; tclass = '0; vc_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    idle(2);

    // phase 0 toward intermediate router 5 from router 0: X step, port 3 (R4 R6 R7)
    drive(0, 3, 16, 10, 0, 2);
    // at intermediate router: switch to phase 1, head to router 0 (R3 R6 R7)
    drive(5, 4, 0, 11, 0, 1);
    // destination router reached while in phase 0: local port, full range (R5 R8)
    drive(8, 2, 17, 3, 0, 3);
    // Y only, target above (R6)
    drive(1, 5, 14, 0, 1, 0);
    // Y only, target below (R6)
    drive(7, 2, 2, 9, 1, 2);
    // sticky phase 1 standing at intermediate router (R9)
    drive(4, 3, 1, 8, 1, 1);
    // terminal input, local destination (R2 R3 R5 R8)
    drive(3, 1, 6, 0, 1, 0);
    idle(2);
    // terminal bursts for fresh draws (R2 R10)
    for (int i = 0; i < 10; i++) drive(4, i % TC, 17, 0, 1, i % 4);
    idle(3);
    // mixed traffic
    for (int i = 0; i < 120; i++) begin
      int rid, chan, ph;
      rid  = $urandom_range(ROUTERS - 1);
      chan = $urandom_range(PORTS - 1);
      ph   = (chan < TC) ? 0 : $urandom_range(1);
      drive(rid, chan, $urandom_range(NODES - 1), $urandom_range(NODES - 1),
            ph, $urandom_range(3));
      if (i % 9 == 0) idle(1);
    end
    idle(4);

    chk("R1 all responses seen", q.size(), 0);
    begin
      int distinct = 0;
      foreach (draws[i]) if (i > 0 && draws[i] != draws[0]) distinct = 1;
      chk("R10 draws vary", distinct, 1);
    end
    report();
  end

endmodule